// File: doc/BRIEF.md
# Programmable Length Serial Shift Register

A one-bit serial delay line whose usable length runs from 1 to 64 stages and is set by a six-bit length code. It stores `len_code + 1` bits. Each shift takes one new bit from one of two serial inputs and pushes everything already stored one stage toward the output. With the second input selected and the output wired back to it, the stored word circulates forever.

A shift is started by activity on two control inputs, `trig_p` and `trig_n`, which are not clocks. Each one passes through a synchronizer into the free-running system clock `clk`. The block looks for edges on the synchronized copies, and a qualified edge makes a one-cycle internal shift enable. The output is a true serial bit plus its complement. A high level on `rst` clears the storage at once, with no clock needed. The internal release of reset lines up with `clk`, and control levels held steady through that release never cause a shift.

Top module: `plsr_top`

## Requirements
- R1: With length code c (0 to 63), a bit written by one shift appears on `sout` right after the (c+1)-th shift counted from and including its own. Code 0 therefore shows it right after the same shift.
- R2: With `sel_b` = 0 the shifted-in bit is `din_a`, and with `sel_b` = 1 it is `din_b`. The input not selected has no effect on the stored data.
- R3: Every shift moves all 64 physical stages, whatever the code. If the code is raised after shifting, `sout` shows the older bits stored in the deeper stages, not zeros.
- R4: A low-to-high transition on `trig_p` while `trig_n` is low causes exactly one shift.
- R5: A high-to-low transition on `trig_n` while `trig_p` is high causes exactly one shift.
- R6: No other activity causes a shift. This covers a `trig_p` rise while `trig_n` is high, any `trig_p` fall, any `trig_n` rise, and a `trig_n` fall while `trig_p` is low.
- R7: While `rst` is high, `sout` is 0 and `sout_n` is 1 with no clock edge needed, and all stages are cleared.
- R8: `sout_n` is always the complement of `sout`.
- R9: Control levels held steady across the release of reset cause no shift, even when they look like a qualified state such as `trig_p` high and `trig_n` low.
- R10: A qualified transition shows its effect on `sout` within four `clk` rising edges, provided the data inputs stay stable over that time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running system clock |
| rst | input | 1 | Active-high master clear; takes effect asynchronously, released in step with `clk` |
| len_code | input | 6 | Length code; the active length is this value plus one |
| din_a | input | 1 | Serial data source used when `sel_b` is 0 |
| din_b | input | 1 | Serial data source used when `sel_b` is 1, for example for recirculation |
| sel_b | input | 1 | Selects the serial source |
| trig_p | input | 1 | Shift control; its rising edge shifts while `trig_n` is low |
| trig_n | input | 1 | Shift control; its falling edge shifts while `trig_p` is high |
| sout | output | 1 | Serial output, taken from the stage the length code selects |
| sout_n | output | 1 | Complement of `sout` |

## Verification
The hardest situation to reach from the ports is the one where the length code is lowered after the deep stages are filled, data keeps shifting, and then the code is raised again. The bench fills all 64 stages at the longest length, shifts a few bits at a short length, and then returns to the long length. Its model keeps the full history of written bits, so it knows exactly which old bit must come out. The bench also holds `trig_p` high and `trig_n` low through every reset so that a spurious shift on release would be visible. It walks the controls through every unqualified transition at length 1, each time with the data input set to the opposite of the output.

// File: rtl/plsr_pkg.sv
package plsr_pkg;

    localparam int unsigned PLSR_DEPTH_DEF = 64;
    localparam int unsigned PLSR_SYNC_DEF  = 2;

    // The two shift-control inputs, kept together through the synchronizer.
    typedef struct packed {
        logic p;
        logic n;
    } trig_pair_t;

    // Edge qualification: rising p while n low, or falling n while p high.
    function automatic logic qualify(input trig_pair_t now_v, input trig_pair_t was_v);
        logic rise_p;
        logic fall_n;
        rise_p = now_v.p & ~was_v.p & ~now_v.n;
        fall_n = was_v.n & ~now_v.n & now_v.p;
        return rise_p | fall_n;
    endfunction

endpackage

// File: rtl/plsr_rst_sync.sv
module plsr_rst_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    output logic rst_q
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            chain_q <= '1;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], 1'b0};
        end
    end

    assign rst_q = chain_q[STAGES-1];
endmodule

// File: rtl/plsr_trig_qual.sv
module plsr_trig_qual
    import plsr_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = PLSR_SYNC_DEF
) (
    input  logic       clk,
    input  logic       rst_q,
    input  trig_pair_t trig_raw,
    output logic       shift_en,
    output logic       armed
);
    localparam int unsigned ARM_LIMIT = SYNC_STAGES + 1;
    localparam int unsigned ARM_W     = $clog2(ARM_LIMIT + 1);

    trig_pair_t       sync_q [SYNC_STAGES];
    trig_pair_t       hist_q;
    logic [ARM_W-1:0] arm_cnt;

    always_ff @(posedge clk or posedge rst_q) begin
        if (rst_q) begin
            for (int i = 0; i < SYNC_STAGES; i++) begin
                sync_q[i] <= '0;
            end
        end else begin
            sync_q[0] <= trig_raw;
            for (int i = 1; i < SYNC_STAGES; i++) begin
                sync_q[i] <= sync_q[i-1];
            end
        end
    end

    always_ff @(posedge clk or posedge rst_q) begin
        if (rst_q) begin
            hist_q <= '0;
        end else begin
            hist_q <= sync_q[SYNC_STAGES-1];
        end
    end

    // Edges are ignored until the synchronizer and history hold real samples.
    always_ff @(posedge clk or posedge rst_q) begin
        if (rst_q) begin
            arm_cnt <= '0;
        end else if (arm_cnt != ARM_W'(ARM_LIMIT)) begin
            arm_cnt <= arm_cnt + 1'b1;
        end
    end

    assign armed    = (arm_cnt == ARM_W'(ARM_LIMIT));
    assign shift_en = armed & qualify(sync_q[SYNC_STAGES-1], hist_q);
endmodule

// File: rtl/plsr_stages.sv
module plsr_stages #(
    parameter int unsigned DEPTH  = 64,
    parameter int unsigned CODE_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_q,
    input  logic              shift_en,
    input  logic              din,
    input  logic [CODE_W-1:0] tap_sel,
    output logic [DEPTH-1:0]  stage_vec,
    output logic              tap_bit
);
    logic [DEPTH-1:0] stage_q;

    always_ff @(posedge clk or posedge rst_q) begin
        if (rst_q) begin
            stage_q <= '0;
        end else if (shift_en) begin
            stage_q <= {stage_q[DEPTH-2:0], din};
        end
    end

    assign stage_vec = stage_q;
    assign tap_bit   = stage_q[tap_sel];
endmodule

// File: rtl/plsr_top.sv
module plsr_top
    import plsr_pkg::*;
#(
    parameter int unsigned DEPTH       = PLSR_DEPTH_DEF,
    parameter int unsigned SYNC_STAGES = PLSR_SYNC_DEF,
    parameter int unsigned CODE_W      = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CODE_W-1:0] len_code,
    input  logic              din_a,
    input  logic              din_b,
    input  logic              sel_b,
    input  logic              trig_p,
    input  logic              trig_n,
    output logic              sout,
    output logic              sout_n
);
    logic             rst_q;
    logic             shift_en;
    logic             armed;
    logic             din_sel;
    logic [DEPTH-1:0] stage_vec;
    trig_pair_t       trig_raw;

    assign trig_raw.p = trig_p;
    assign trig_raw.n = trig_n;
    assign din_sel    = sel_b ? din_b : din_a;

    plsr_rst_sync #(.STAGES(2)) u_rst (
        .clk   (clk),
        .rst   (rst),
        .rst_q (rst_q)
    );

    plsr_trig_qual #(.SYNC_STAGES(SYNC_STAGES)) u_qual (
        .clk      (clk),
        .rst_q    (rst_q),
        .trig_raw (trig_raw),
        .shift_en (shift_en),
        .armed    (armed)
    );

    plsr_stages #(.DEPTH(DEPTH), .CODE_W(CODE_W)) u_stg (
        .clk       (clk),
        .rst_q     (rst_q),
        .shift_en  (shift_en),
        .din       (din_sel),
        .tap_sel   (len_code),
        .stage_vec (stage_vec),
        .tap_bit   (sout)
    );

    assign sout_n = ~sout;
endmodule

// File: rtl/plsr_checker.sv
module plsr_checker #(
    parameter int unsigned DEPTH = 64
) (
    input logic             clk,
    input logic             rst,
    input logic             rst_q,
    input logic             shift_en,
    input logic             armed,
    input logic [DEPTH-1:0] stages,
    input logic             din_a,
    input logic             din_b,
    input logic             sel_b,
    input logic             sout,
    input logic             sout_n
);
    // R2: the selected source lands in the first stage
    a_r2_select: assert property (@(posedge clk) disable iff (rst_q)
        shift_en |=> stages[0] == $past(sel_b ? din_b : din_a));

    // R3: every stage moves one place per shift
    a_r3_advance: assert property (@(posedge clk) disable iff (rst_q)
        shift_en |=> stages[DEPTH-1:1] == $past(stages[DEPTH-2:0]));

    // R6: without a qualified edge nothing moves
    a_r6_hold: assert property (@(posedge clk) disable iff (rst_q)
        !shift_en |=> $stable(stages));

    // R4: one transition gives one pulse
    a_r4_single_pulse: assert property (@(posedge clk) disable iff (rst_q)
        shift_en |=> !shift_en);

    // R7: reset holds the outputs at their cleared levels
    a_r7_reset: assert property (@(posedge clk)
        rst |-> (!sout && sout_n && stages == '0));

    // R9: no shift before the edge history is valid
    a_r9_quiet: assert property (@(posedge clk) disable iff (rst_q)
        !armed |-> !shift_en);
endmodule

bind plsr_top plsr_checker #(.DEPTH(DEPTH)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .rst_q    (rst_q),
    .shift_en (shift_en),
    .armed    (armed),
    .stages   (stage_vec),
    .din_a    (din_a),
    .din_b    (din_b),
    .sel_b    (sel_b),
    .sout     (sout),
    .sout_n   (sout_n)
);

// File: tb/plsr_top_bench.sv
module plsr_top_bench;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 64;
    localparam int WATCHDOG   = 200000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [5:0] len_code = '0;
    logic       din_a = 1'b0;
    logic       din_b = 1'b0;
    logic       sel_b = 1'b0;
    logic       trig_p = 1'b1;
    logic       trig_n = 1'b0;
    logic       sout;
    logic       sout_n;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    int nshift = 0;
    bit hist [0:8191];

    plsr_top u_plsr_top (
        .clk(clk), .rst(rst), .len_code(len_code), .din_a(din_a), .din_b(din_b),
        .sel_b(sel_b), .trig_p(trig_p), .trig_n(trig_n), .sout(sout), .sout_n(sout_n)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > WATCHDOG) begin
            fails = fails + 1;
            $display("FAIL watchdog: actual=%0d cycles expected<=%0d", cycles, WATCHDOG);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual=%b expected=%b (shift %0d code %0d)",
                     req, act, exp, nshift, len_code);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic expect_out();
        int len;
        len = int'(len_code) + 1;
        return (nshift >= len) ? logic'(hist[nshift - len]) : 1'b0;
    endfunction

    task automatic check_out(input string req);
        check(req, sout, expect_out());
        check("R8", sout_n, ~sout);
    endtask

    // Qualified rising edge on trig_p with trig_n low (R4).
    task automatic pulse_p();
        trig_p = 1'b0; wait_cyc(5);
        trig_n = 1'b0; wait_cyc(5);
        trig_p = 1'b1; wait_cyc(5);
    endtask

    // Qualified falling edge on trig_n with trig_p high (R5); starts from p=1,n=0.
    task automatic pulse_n();
        trig_n = 1'b1; wait_cyc(5);
        trig_n = 1'b0; wait_cyc(5);
    endtask

    task automatic shift_bit(input bit b, input bit via_n, input string req);
        if (sel_b) begin din_b = b; din_a = ~b; end
        else       begin din_a = b; din_b = ~b; end
        hist[nshift] = b;
        nshift++;
        if (via_n) pulse_n(); else pulse_p();
        check_out(req);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        #1;
        check("R7", sout, 1'b0);
        check("R7", sout_n, 1'b1);
        wait_cyc(3);
        rst = 1'b0;
        wait_cyc(8);
        nshift = 0;
    endtask

    initial begin
        wait_cyc(4);
        rst = 1'b0;
        wait_cyc(8);

        // R9: trig_p high / trig_n low held through reset release, din high
        len_code = 6'd0; din_a = 1'b1;
        do_reset();
        wait_cyc(6);
        check("R9", sout, 1'b0);

        // R1/R2/R4/R5: sweep all length codes, alternating source and trigger
        for (int c = 0; c < DEPTH; c++) begin
            do_reset();
            len_code = 6'(c);
            sel_b = c[0];
            check_out("R1");
            for (int s = 0; s < c + 4; s++) begin
                shift_bit(bit'(((s * 5 + c * 3) % 7) < 3), bit'(s[0]),
                          (s[0] ? "R5" : (c[0] ? "R2" : "R1")));
            end
        end

        // R6: unqualified transitions at length 1 with data opposite to output
        do_reset();
        len_code = 6'd0; sel_b = 1'b0;
        shift_bit(1'b1, 1'b0, "R4");
        din_a = ~sout;
        trig_p = 1'b0; wait_cyc(6); check("R6", sout, 1'b1);  // p fall
        trig_n = 1'b1; wait_cyc(6); check("R6", sout, 1'b1);  // n rise, p low
        trig_n = 1'b0; wait_cyc(6); check("R6", sout, 1'b1);  // n fall, p low
        trig_n = 1'b1; wait_cyc(6);
        trig_p = 1'b1; wait_cyc(6); check("R6", sout, 1'b1);  // p rise, n high
        trig_p = 1'b0; wait_cyc(6); check("R6", sout, 1'b1);
        trig_n = 1'b0; wait_cyc(6);
        trig_p = 1'b1; wait_cyc(6); check("R4", sout, 1'b0);  // qualified again

        // R10: effect visible by the fourth clock edge
        do_reset();
        len_code = 6'd0; din_a = 1'b1;
        trig_p = 1'b0; wait_cyc(5);
        trig_p = 1'b1; wait_cyc(4);
        check("R10", sout, 1'b1);
        wait_cyc(4);

        // R3: fill deep stages, shorten, shift, lengthen again
        do_reset();
        len_code = 6'd63; sel_b = 1'b0;
        for (int s = 0; s < DEPTH; s++) shift_bit(bit'((s % 3) == 0), 1'b0, "R3");
        len_code = 6'd3;
        check_out("R3");
        for (int s = 0; s < 3; s++) shift_bit(bit'(s == 1), 1'b1, "R3");
        len_code = 6'd63; wait_cyc(1); check_out("R3");
        len_code = 6'd40; wait_cyc(1); check_out("R3");
        len_code = 6'd10; wait_cyc(1); check_out("R3");

        // R2: recirculation at length 8 through din_b
        do_reset();
        len_code = 6'd7; sel_b = 1'b0;
        for (int s = 0; s < 8; s++) shift_bit(bit'(s == 0 || s == 5), 1'b0, "R2");
        sel_b = 1'b1;
        for (int s = 0; s < 16; s++) shift_bit(sout, bit'(s[0]), "R2");
        check("R2", sout, hist[nshift - 8]);

        // R7: reset mid-pattern clears deep data too
        do_reset();
        len_code = 6'd63; wait_cyc(1);
        check("R7", sout, 1'b0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule